// File: doc/BRIEF.md
# Eight-Lane Wide Accumulator with Saturating Readout

This block holds the running sums of a fixed-point vector unit. It keeps eight lanes of 48 bits each. Every lane is read as a signed two's-complement number. An upstream producer, such as a multiplier array, offers one 384-bit word of per-lane values per transfer. Each transfer either replaces the lanes or adds into them.

Two 128-bit results, each eight lanes of 16 bits, are always available for writing back to a vector register. The slice result picks one 16-bit third of every lane. The saturated result limits each lane to 16 bits under a signed rule or an unsigned rule. Both results depend only on the present lane contents and the two select pins, so they follow a change of state in the cycle after the accepting edge.

The operation input is a valid/ready stream. A transfer happens on a rising clock edge when `op_valid` and `op_ready` are both high. `op_ready` is low while reset is asserted and high at all other times, so the block never applies back-pressure outside reset. A producer may hold `op_valid` high across any number of cycles, and each accepting edge applies the word once. The select pins are plain control inputs.

Top module: `simd_acc`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight lanes to zero, and `op_ready` is low while `rst` is high.
- R2: An accepted transfer with `op_load` high writes every lane from `op_data`. Lane 0 is taken from bits 383:336 and lane 7 from bits 47:0.
- R3: An accepted transfer with `op_add` high and `op_load` low adds each 48-bit `op_data` lane to the matching accumulator lane, wrapping modulo 2^48.
- R4: When `op_load` and `op_add` are both high in an accepted transfer, the load is applied and the add is ignored.
- R5: The lanes keep their values on any edge without an accepted transfer, and on an accepted transfer with both `op_load` and `op_add` low.
- R6: `slice_sel` picks the part of each lane that `slice_out` shows: 0 gives bits 15:0, 1 gives bits 31:16, 2 gives bits 47:32, and 3 gives zero.
- R7: With `clamp_mode` = 0 (signed), each `clamp_out` lane is 0x8000 when the lane is below -32768, 0x7FFF when it is above 32767, and the lane's low 16 bits otherwise.
- R8: With `clamp_mode` = 1 (unsigned), each `clamp_out` lane is 0x0000 when the lane is negative, 0xFFFF when it is above 32767, and the lane's low 16 bits otherwise.
- R9: In both outputs, lane 0 occupies bits 127:112 and lane 7 occupies bits 15:0.
- R10: `op_ready` is high on every cycle in which `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Producer offers an operation word |
| op_ready | output | 1 | Block can accept a word (low only in reset) |
| op_load | input | 1 | Replace lanes with the word (takes priority) |
| op_add | input | 1 | Add the word into the lanes |
| op_data | input | 384 | Eight 48-bit lane values, lane 0 in the top bits |
| slice_sel | input | 2 | Portion select for `slice_out` |
| clamp_mode | input | 1 | 0 signed saturation, 1 unsigned saturation |
| slice_out | output | 128 | Selected 16-bit portion of each lane |
| clamp_out | output | 128 | Saturated 16-bit value of each lane |

## Verification
The assertions assume that `op_valid`, `op_load`, `op_add` and `clamp_mode` carry known values at every edge outside reset, and that `op_data` is fully known whenever a transfer is accepted. The bench drives every input to a defined value from time zero. It changes stream inputs only on falling edges and changes the select pins only between edges, so every sampled combination is legal. The lane values are picked on both sides of each saturation threshold and at the 48-bit extremes so that wraparound is exercised. Transfers with `op_valid` low carry live load and add flags, so the no-transfer case is checked against words that would otherwise change the lanes.

// File: rtl/simd_acc_pkg.sv
package simd_acc_pkg;

  localparam int unsigned DEF_LANES = 8;
  localparam int unsigned DEF_OUT_W = 16;
  localparam int unsigned DEF_ACC_W = 3 * DEF_OUT_W;

  // Portion encodings for the raw slice read
  typedef enum logic [1:0] {
    PART_LOW  = 2'd0,
    PART_MID  = 2'd1,
    PART_HIGH = 2'd2,
    PART_NONE = 2'd3
  } part_sel_e;

  // Saturation rule encodings
  typedef enum logic {
    SAT_SIGNED   = 1'b0,
    SAT_UNSIGNED = 1'b1
  } sat_mode_e;

  // Lane update command decoded from the stream beat
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_SUM  = 2'd2
  } lane_upd_e;

endpackage

// File: rtl/simd_acc_lane.sv
module simd_acc_lane
  import simd_acc_pkg::*;
#(
  parameter int unsigned ACC_W = DEF_ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  lane_upd_e        upd,
  input  logic [ACC_W-1:0] operand,
  output logic [ACC_W-1:0] value
);

  logic [ACC_W-1:0] value_q;
  logic [ACC_W-1:0] value_d;

  // Sum is taken at full lane width, dropping the carry out (wraparound)
  always_comb begin
    unique case (upd)
      UPD_LOAD: value_d = operand;
      UPD_SUM:  value_d = value_q + operand;
      default:  value_d = value_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) value_q <= '0;
    else     value_q <= value_d;
  end

  assign value = value_q;

endmodule

// File: rtl/simd_acc_slicer.sv
module simd_acc_slicer
  import simd_acc_pkg::*;
#(
  parameter int unsigned OUT_W = DEF_OUT_W,
  parameter int unsigned ACC_W = 3 * OUT_W
) (
  input  part_sel_e        part,
  input  logic [ACC_W-1:0] lane,
  output logic [OUT_W-1:0] piece
);

  localparam int unsigned NPARTS = ACC_W / OUT_W;

  logic [OUT_W-1:0] parts [NPARTS];

  for (genvar p = 0; p < NPARTS; p++) begin : g_part
    assign parts[p] = lane[p*OUT_W +: OUT_W];
  end

  always_comb begin
    unique case (part)
      PART_LOW:  piece = parts[0];
      PART_MID:  piece = parts[1];
      PART_HIGH: piece = parts[2];
      default:   piece = '0;
    endcase
  end

endmodule

// File: rtl/simd_acc_sat.sv
module simd_acc_sat
  import simd_acc_pkg::*;
#(
  parameter int unsigned OUT_W = DEF_OUT_W,
  parameter int unsigned ACC_W = 3 * OUT_W
) (
  input  sat_mode_e        mode,
  input  logic [ACC_W-1:0] lane,
  output logic [OUT_W-1:0] sat
);

  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] ALL_ONE = {OUT_W{1'b1}};

  logic neg;
  logic over_pos;
  logic under_neg;

  // Bits from OUT_W-1 up to ACC_W-2 must all match the sign bit
  // for the lane to fit in a signed OUT_W-bit value.
  assign neg       = lane[ACC_W-1];
  assign over_pos  = !neg && (|lane[ACC_W-2:OUT_W-1]);
  assign under_neg =  neg && !(&lane[ACC_W-2:OUT_W-1]);

  always_comb begin
    sat = lane[OUT_W-1:0];
    if (mode == SAT_SIGNED) begin
      if (over_pos)       sat = POS_MAX;
      else if (under_neg) sat = NEG_MIN;
    end else begin
      if (neg)            sat = '0;
      else if (over_pos)  sat = ALL_ONE;
    end
  end

endmodule

// File: rtl/simd_acc.sv
module simd_acc
  import simd_acc_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned OUT_W = DEF_OUT_W,
  parameter int unsigned ACC_W = 3 * OUT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   op_valid,
  output logic                   op_ready,
  input  logic                   op_load,
  input  logic                   op_add,
  input  logic [LANES*ACC_W-1:0] op_data,
  input  logic [1:0]             slice_sel,
  input  logic                   clamp_mode,
  output logic [LANES*OUT_W-1:0] slice_out,
  output logic [LANES*OUT_W-1:0] clamp_out
);

  localparam int unsigned IN_W  = LANES * ACC_W;
  localparam int unsigned VEC_W = LANES * OUT_W;

  logic       take;
  lane_upd_e  upd;
  part_sel_e  part;
  sat_mode_e  mode;
  logic [IN_W-1:0] acc_flat;

  assign op_ready = !rst;
  assign take     = op_valid && op_ready;
  assign part     = part_sel_e'(slice_sel);
  assign mode     = sat_mode_e'(clamp_mode);

  // Load wins over add
  always_comb begin
    upd = UPD_HOLD;
    if (take) begin
      if (op_load)     upd = UPD_LOAD;
      else if (op_add) upd = UPD_SUM;
    end
  end

  // Lane 0 sits in the most significant slot of every wide word
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned IN_LSB  = (LANES - 1 - i) * ACC_W;
    localparam int unsigned OUT_LSB = (LANES - 1 - i) * OUT_W;

    logic [ACC_W-1:0] lane_val;

    simd_acc_lane #(.ACC_W(ACC_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .upd     (upd),
      .operand (op_data[IN_LSB +: ACC_W]),
      .value   (lane_val)
    );

    simd_acc_slicer #(.OUT_W(OUT_W), .ACC_W(ACC_W)) u_slice (
      .part  (part),
      .lane  (lane_val),
      .piece (slice_out[OUT_LSB +: OUT_W])
    );

    simd_acc_sat #(.OUT_W(OUT_W), .ACC_W(ACC_W)) u_sat (
      .mode (mode),
      .lane (lane_val),
      .sat  (clamp_out[OUT_LSB +: OUT_W])
    );

    assign acc_flat[IN_LSB +: ACC_W] = lane_val;
  end

  logic unused_w;
  assign unused_w = ^VEC_W;

endmodule

// File: rtl/simd_acc_chk.sv
module simd_acc_chk #(
  parameter int unsigned LANES = 8,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned ACC_W = 48
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   op_valid,
  input logic                   op_ready,
  input logic                   op_load,
  input logic                   op_add,
  input logic [LANES*ACC_W-1:0] op_data,
  input logic                   clamp_mode,
  input logic [LANES*ACC_W-1:0] acc_flat,
  input logic [LANES*OUT_W-1:0] clamp_out
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> acc_flat == '0);

  // R10
  ready_up_chk: assert property (@(posedge clk) disable iff (rst) op_ready);

  // R2
  load_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_load) |=> acc_flat == $past(op_data));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && (op_load || op_add)) |=> $stable(acc_flat));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    localparam int unsigned A = (LANES - 1 - i) * ACC_W;
    localparam int unsigned O = (LANES - 1 - i) * OUT_W;

    // R7
    sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !clamp_mode |-> clamp_out[O+OUT_W-1] == acc_flat[A+ACC_W-1]);

    // R8
    neg_floor_chk: assert property (@(posedge clk) disable iff (rst)
      (clamp_mode && acc_flat[A+ACC_W-1]) |-> clamp_out[O +: OUT_W] == '0);
  end

endmodule

bind simd_acc simd_acc_chk #(.LANES(LANES), .OUT_W(OUT_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .op_load    (op_load),
  .op_add     (op_add),
  .op_data    (op_data),
  .clamp_mode (clamp_mode),
  .acc_flat   (acc_flat),
  .clamp_out  (clamp_out)
);

// File: tb/simd_acc_bench.sv
`timescale 1ns/1ps
module simd_acc_bench;

  localparam int NL = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic         op_ready;
  logic         op_load = 1'b0;
  logic         op_add = 1'b0;
  logic [383:0] op_data = '0;
  logic [1:0]   slice_sel = 2'd0;
  logic         clamp_mode = 1'b0;
  logic [127:0] slice_out;
  logic [127:0] clamp_out;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic [47:0] model [NL];

  always #10 clk = ~clk;

  simd_acc u_simd_acc (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_load(op_load), .op_add(op_add), .op_data(op_data),
    .slice_sel(slice_sel), .clamp_mode(clamp_mode),
    .slice_out(slice_out), .clamp_out(clamp_out)
  );

  function automatic logic [15:0] ref_sat(input logic [47:0] v, input logic m);
    longint s = longint'($signed(v));
    if (!m) begin
      if (s < -32768) return 16'h8000;
      if (s > 32767)  return 16'h7FFF;
      return v[15:0];
    end
    if (s < 0)     return 16'h0000;
    if (s > 32767) return 16'hFFFF;
    return v[15:0];
  endfunction

  function automatic logic [15:0] ref_slice(input logic [47:0] v, input logic [1:0] s);
    case (s)
      2'd0: return v[15:0];
      2'd1: return v[31:16];
      2'd2: return v[47:32];
      default: return 16'h0;
    endcase
  endfunction

  // Full sweep of both output views against the model (R6, R7, R8, R9)
  task automatic compare_all(input string tag);
    logic [127:0] exp_v;
    vectors++;
    if (op_ready !== !rst) begin
      miscompares++;
      $display("FAIL R10 %s op_ready act=%b exp=%b", tag, op_ready, !rst);
    end
    for (int s = 0; s < 4; s++) begin
      slice_sel = 2'(s);
      #1;
      for (int i = 0; i < NL; i++) exp_v[(NL-1-i)*16 +: 16] = ref_slice(model[i], 2'(s));
      vectors++;
      if (slice_out !== exp_v) begin
        miscompares++;
        $display("FAIL R6 %s sel=%0d act=%h exp=%h", tag, s, slice_out, exp_v);
      end
    end
    for (int m = 0; m < 2; m++) begin
      clamp_mode = 1'(m);
      #1;
      for (int i = 0; i < NL; i++) exp_v[(NL-1-i)*16 +: 16] = ref_sat(model[i], 1'(m));
      vectors++;
      if (clamp_out !== exp_v) begin
        miscompares++;
        $display("FAIL %s %s act=%h exp=%h", m ? "R8" : "R7", tag, clamp_out, exp_v);
      end
    end
  endtask

  task automatic step(input logic v, input logic ld, input logic ad,
                      input logic [383:0] d, input string tag);
    @(negedge clk);
    op_valid = v; op_load = ld; op_add = ad; op_data = d;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < NL; i++) model[i] = '0;
    end else if (v) begin
      for (int i = 0; i < NL; i++) begin
        if (ld)      model[i] = d[(NL-1-i)*48 +: 48];
        else if (ad) model[i] = model[i] + d[(NL-1-i)*48 +: 48];
      end
    end
    #1;
    compare_all(tag);
  endtask

  function automatic logic [383:0] pack(input logic [47:0] l [NL]);
    logic [383:0] r;
    for (int i = 0; i < NL; i++) r[(NL-1-i)*48 +: 48] = l[i];
    return r;
  endfunction

  function automatic logic [383:0] rnd_word();
    logic [383:0] r;
    for (int i = 0; i < NL; i++) begin
      logic [63:0] t = {$urandom(), $urandom()};
      r[i*48 +: 48] = t[47:0];
    end
    return r;
  endfunction

  function automatic logic [383:0] rnd_small();
    logic [383:0] r;
    for (int i = 0; i < NL; i++) begin
      logic [47:0] t = 48'($signed(17'($urandom())));
      r[i*48 +: 48] = t;
    end
    return r;
  endfunction

  initial begin
    logic [47:0] lv [NL];
    for (int i = 0; i < NL; i++) model[i] = '0;

    // R1: reset state
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0, '0, "R1 reset");
    step(1'b1, 1'b1, 1'b0, rnd_word(), "R1 reset ignores load");
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b0, '0, "R1 after reset");

    // R2, R9: load with distinct lanes, lane 0 in top bits
    for (int i = 0; i < NL; i++) lv[i] = 48'h111111111111 * 48'(i + 1);
    step(1'b1, 1'b1, 1'b0, pack(lv), "R2 R9 ordered load");

    // R7, R8: values around the saturation thresholds
    lv[0] = 48'sd32767;  lv[1] = 48'sd32768;  lv[2] = -48'sd32768; lv[3] = -48'sd32769;
    lv[4] = -48'sd1;     lv[5] = 48'd0;       lv[6] = 48'd65535;   lv[7] = 48'h7FFFFFFFFFFF;
    step(1'b1, 1'b1, 1'b0, pack(lv), "R7 R8 thresholds");
    lv[0] = 48'h800000000000; lv[1] = 48'sd1;  lv[2] = 48'd12345; lv[3] = 48'h000100000000;
    lv[4] = -48'sd12345;      lv[5] = 48'hFFFF00000000; lv[6] = 48'd32769; lv[7] = -48'sd2;
    step(1'b1, 1'b1, 1'b0, pack(lv), "R7 R8 extremes");

    // R3: wraparound at 48 bits
    for (int i = 0; i < NL; i++) lv[i] = (i % 2) ? 48'h800000000000 : 48'h7FFFFFFFFFFF;
    step(1'b1, 1'b1, 1'b0, pack(lv), "R3 preload");
    for (int i = 0; i < NL; i++) lv[i] = (i % 2) ? -48'sd1 : 48'sd1;
    step(1'b1, 1'b0, 1'b1, pack(lv), "R3 wrap");
    step(1'b1, 1'b0, 1'b1, pack(lv), "R3 wrap back");

    // R4: load and add together, load wins
    step(1'b1, 1'b1, 1'b1, rnd_word(), "R4 load priority");

    // R5: no accepted transfer, or no operation selected
    step(1'b0, 1'b1, 1'b1, rnd_word(), "R5 valid low");
    step(1'b1, 1'b0, 1'b0, rnd_word(), "R5 no op");

    // Mixed traffic, small values so sums cross the clamp thresholds
    step(1'b1, 1'b1, 1'b0, '0, "R2 clear");
    for (int n = 0; n < 120; n++) begin
      logic [2:0] k = 3'($urandom());
      case (k)
        3'd0:    step(1'b1, 1'b1, 1'b0, rnd_word(), "R2 mix load");
        3'd1:    step(1'b1, 1'b1, 1'b1, rnd_small(), "R4 mix both");
        3'd2:    step(1'b0, 1'($urandom()), 1'($urandom()), rnd_word(), "R5 mix idle");
        default: step(1'b1, 1'b0, 1'b1, rnd_small(), "R3 mix add");
      endcase
    end

    // R1: reset after activity clears lanes
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b1, rnd_word(), "R1 late reset");
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b0, '0, "R1 late reset done");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule